// File: doc/BRIEF.md
# Fixed-to-Float Range Converter

This block turns an unsigned fixed-point word into an unsigned floating pair, a mantissa `M` and an exponent `E`, whose value is `M × 2^E`. There is no sign bit. The input width, mantissa width and exponent width are parameters. The defaults are a 15-bit input, an 8-bit mantissa and a 3-bit exponent.

Inputs that fit in the mantissa pass through unchanged with a zero exponent. No normalization is applied to them, so the exponent never has to go negative. A wider input is aligned so that its highest set bit lands in the mantissa MSB. Bits that fall below the mantissa LSB are dropped by truncation. If the consumer wants a fractional reading, it applies its own fixed offset to the exponent.

The converter has one register stage. A sample presented with `in_valid` comes out one clock later with `out_valid`. Between samples the outputs keep their last value.

Top module: `f2f_convert`

The block has no states. Its only sequential element is the output register. That register has two transitions:
- LOAD, taken on a clock edge with `in_valid` high.
- HOLD, taken on a clock edge with `in_valid` low.

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_mant` is 0 and `out_exp` is 0.
- R2: `out_valid` at a clock edge equals the `in_valid` seen at the previous edge (LOAD raises it, HOLD clears it).
- R3: An input below 2^MAN_W (0 to 255 by default) gives `out_mant` equal to the input and `out_exp` equal to 0.
- R4: An input of 2^MAN_W or more gives `out_mant[MAN_W-1]` = 1 and `out_exp` = (index of the highest set input bit) − (MAN_W − 1).
- R5: `out_mant` equals input bits [E+MAN_W−1 : E] by truncation. So `out_mant << out_exp` never exceeds the input, and the input minus that value is less than 2^`out_exp`.
- R6: `out_exp` never exceeds IN_W − MAN_W. The all-ones input gives the largest exponent (7 by default) and an all-ones mantissa.
- R7: While `in_valid` is low (HOLD), `out_mant` and `out_exp` keep their values whatever `in_data` carries.
- R8: At the range edge, 255 gives M=255, E=0 and 256 gives M=128, E=1. The input 0x4410 gives M=0x88, E=7.
- R9: Elaboration stops with an error unless 2^EXP_W − 1 ≥ IN_W − MAN_W and IN_W > MAN_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe for `in_data` |
| in_data | input | IN_W | Unsigned fixed-point input |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_mant | output | MAN_W | Mantissa, unnormalized for small inputs |
| out_exp | output | EXP_W | Unsigned exponent |

## Verification
The bench builds the converter with its default widths: 15-bit input, 8-bit mantissa, 3-bit exponent. With these widths the whole input space of 32768 values can be swept. Every exponent from 0 to 7 is reached, and every truncation pattern below the mantissa is covered. A seeded random stream with gaps in `in_valid` exercises back-to-back LOAD transitions and HOLD with changing data.

// File: rtl/f2f_pkg.sv
package f2f_pkg;

    // Smallest exponent width able to express every shift 0..in_w-man_w.
    function automatic int exp_bits_needed(input int in_w, input int man_w);
        return $clog2(in_w - man_w + 1);
    endfunction

endpackage

// File: rtl/f2f_lead_detect.sv
module f2f_lead_detect #(
    parameter int IN_W  = 15,
    parameter int MAN_W = 8,
    parameter int EXP_W = 3
) (
    input  logic [IN_W-1:0]  data,
    output logic [EXP_W-1:0] shift
);
    // Scan only the bits above the mantissa window; the highest set one wins.
    always_comb begin
        shift = '0;
        for (int i = MAN_W; i < IN_W; i++) begin
            if (data[i]) begin
                shift = EXP_W'(i - MAN_W + 1);
            end
        end
    end
endmodule

// File: rtl/f2f_align.sv
module f2f_align #(
    parameter int IN_W  = 15,
    parameter int MAN_W = 8,
    parameter int EXP_W = 3
) (
    input  logic [IN_W-1:0]  data,
    input  logic [EXP_W-1:0] shift,
    output logic [MAN_W-1:0] mant
);
    logic [IN_W-1:0] shifted;

    // Right shift by the exponent; low bits fall off (truncation).
    always_comb begin
        shifted = data >> shift;
        mant    = shifted[MAN_W-1:0];
    end
endmodule

// File: rtl/f2f_convert.sv
module f2f_convert #(
    parameter int IN_W  = 15,
    parameter int MAN_W = 8,
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [MAN_W-1:0] out_mant,
    output logic [EXP_W-1:0] out_exp
);
    import f2f_pkg::*;

    localparam int SPAN     = IN_W - MAN_W;
    localparam int EXP_NEED = exp_bits_needed(IN_W, MAN_W);

    // R9: width legality checked at elaboration
    generate
        if (IN_W <= MAN_W) begin : g_bad_in_w
            $error("f2f_convert: IN_W must exceed MAN_W");
        end
        if (EXP_W < EXP_NEED || ((1 << EXP_W) - 1) < SPAN) begin : g_bad_exp_w
            $error("f2f_convert: EXP_W too narrow for IN_W-MAN_W");
        end
    endgenerate

    logic [EXP_W-1:0] shift_c;
    logic [MAN_W-1:0] mant_c;

    f2f_lead_detect #(.IN_W(IN_W), .MAN_W(MAN_W), .EXP_W(EXP_W)) u_lead (
        .data  (in_data),
        .shift (shift_c)
    );

    f2f_align #(.IN_W(IN_W), .MAN_W(MAN_W), .EXP_W(EXP_W)) u_align (
        .data  (in_data),
        .shift (shift_c),
        .mant  (mant_c)
    );

    // Output register: LOAD on in_valid, HOLD otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mant  <= '0;
            out_exp   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mant <= mant_c;
                out_exp  <= shift_c;
            end
        end
    end
endmodule

// File: rtl/f2f_convert_chk.sv
module f2f_convert_chk #(
    parameter int IN_W  = 15,
    parameter int MAN_W = 8,
    parameter int EXP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic [MAN_W-1:0] out_mant,
    input logic [EXP_W-1:0] out_exp
);
    localparam logic [IN_W-1:0]  SMALL_LIM = IN_W'(1) << MAN_W;
    localparam logic [EXP_W-1:0] EXP_MAX   = EXP_W'(IN_W - MAN_W);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (!out_valid && out_mant == '0 && out_exp == '0); // R1
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_SMALL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data < SMALL_LIM) |=>
        (out_exp == '0 && IN_W'(out_mant) == $past(in_data))); // R3
    AST_LARGE_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data >= SMALL_LIM) |=> out_mant[MAN_W-1]); // R4
    AST_TRUNC_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((IN_W'(out_mant) << out_exp) ==
                      (($past(in_data) >> out_exp) << out_exp))); // R5
    AST_EXP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_exp <= EXP_MAX); // R6
    AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mant) && $stable(out_exp))); // R7
endmodule

bind f2f_convert f2f_convert_chk #(.IN_W(IN_W), .MAN_W(MAN_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/f2f_convert_bench.sv
`timescale 1ns/1ps
module f2f_convert_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 15;
    localparam int MAN_W = 8;
    localparam int EXP_W = 3;
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             out_valid;
    logic [MAN_W-1:0] out_mant;
    logic [EXP_W-1:0] out_exp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2f_convert #(.IN_W(IN_W), .MAN_W(MAN_W), .EXP_W(EXP_W)) u_f2f_convert (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_mant(out_mant), .out_exp(out_exp)
    );

    // Expected exponent: smallest shift bringing the value inside the mantissa.
    function automatic int ref_exp(input int d);
        int e = 0;
        while ((d >> e) >= (1 << MAN_W)) e++;
        return e;
    endfunction

    function automatic int ref_mant(input int d);
        return (d >> ref_exp(d)) % (1 << MAN_W);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // One LOAD then one HOLD with scrambled data; checks land after each edge.
    task automatic send(input int d, input string tag);
        int em, ee, held_m, held_e;
        em = ref_mant(d);
        ee = ref_exp(d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = IN_W'(d);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 valid after load", int'(out_valid), 1);
        chk(int'(out_mant) == em, {tag, " mantissa"}, int'(out_mant), em);
        chk(int'(out_exp) == ee, {tag, " exponent"}, int'(out_exp), ee);
        chk((int'(out_mant) << int'(out_exp)) <= d &&
            d - (int'(out_mant) << int'(out_exp)) < (1 << int'(out_exp)),
            "R5 truncation bound", int'(out_mant) << int'(out_exp), d);
        chk(int'(out_exp) <= IN_W - MAN_W, "R6 exponent bound", int'(out_exp), IN_W - MAN_W);
        if (d >= (1 << MAN_W)) begin
            chk(out_mant[MAN_W-1] == 1'b1, "R4 mantissa msb", int'(out_mant[MAN_W-1]), 1);
        end
        held_m = int'(out_mant);
        held_e = int'(out_exp);
        in_valid = 1'b0;
        in_data  = ~IN_W'(d);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 valid drops", int'(out_valid), 0);
        chk(int'(out_mant) == held_m && int'(out_exp) == held_e, "R7 hold",
            int'(out_mant) * 16 + int'(out_exp), held_m * 16 + held_e);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset holds outputs clear even with a strobe present
        in_valid = 1'b1;
        in_data  = '1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(out_mant == '0, "R1 reset mantissa", int'(out_mant), 0);
        chk(out_exp == '0, "R1 reset exponent", int'(out_exp), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Directed corners
        send(0,      "R3 zero");
        send(255,    "R8 top of small range");
        send(256,    "R8 bottom of large range");
        send(511,    "R4 e1 top");
        send(512,    "R4 e2 bottom");
        send(16'h4410, "R8 worked example");
        send(32767,  "R6 all ones");
        chk(int'(out_mant) == 255 && int'(out_exp) == 7, "R6 all ones pair",
            int'(out_mant) * 16 + int'(out_exp), 255 * 16 + 7);

        // Exhaustive sweep
        for (int d = 0; d < (1 << IN_W); d++) begin
            send(d, (d < (1 << MAN_W)) ? "R3 sweep" : "R4 sweep");
        end

        // Random stream with gaps: compare each cycle with the previous drive
        begin
            bit pv = 1'b0;
            int pd = 0;
            int lm = int'(out_mant);
            int le = int'(out_exp);
            for (int k = 0; k < 2000; k++) begin
                @(negedge clk);
                if (k > 0) begin
                    chk(out_valid == pv, "R2 stream valid", int'(out_valid), int'(pv));
                    if (pv) begin
                        lm = ref_mant(pd);
                        le = ref_exp(pd);
                    end
                    chk(int'(out_mant) == lm, pv ? "R5 stream mantissa" : "R7 stream hold mantissa",
                        int'(out_mant), lm);
                    chk(int'(out_exp) == le, pv ? "R4 stream exponent" : "R7 stream hold exponent",
                        int'(out_exp), le);
                end
                pv = ($urandom % 4) != 0;
                pd = int'($urandom % (1 << IN_W));
                in_valid = pv;
                in_data  = IN_W'(pd);
            end
            @(negedge clk);
            in_valid = 1'b0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule